// File: doc/BRIEF.md
# Linear Frequency Sweep Controller

This block generates the 48-bit tuning word that feeds a phase accumulator. When sweeping is switched off it is a plain single-tone source: the output is the programmed start word. When sweeping is switched on, a frequency accumulator is loaded with the start word. It then grows by a delta word at fixed intervals until it meets the end word. The interval is set by a down counter that runs on the sync clock and reloads from a ramp-rate value.

A sweep is launched by a rising edge on an asynchronous profile-select pin. The pin is synchronized before the edge is detected. At the end of a sweep the output either dwells on the end word or falls back to the start word, depending on a control bit. It stays there until the next launch. An update strobe can restart the current step's countdown, or clear the accumulator and restart the sweep. A static clear bit pins the accumulator at zero.

Top module: `lin_sweep`

## Requirements
- R1: While `sweepEn` is 0, `tuningWord` equals `startWord` in the same cycle and `sweepDone` is 0 from the next clock edge on.
- R2: While sweeping with ramp value N, the accumulator grows by `deltaWord` once every N+1 clock cycles. The first step lands N+1 edges after the edge that loads the start word.
- R3: With `reloadOnUpd` = 1, an `updStrobe` cycle during a sweep reloads the countdown with the ramp value and takes no step on that edge. With `reloadOnUpd` = 0, `updStrobe` has no effect on the step timing.
- R4: With `noDwell` = 0, the step that meets or passes `endWord` sets the output to exactly `endWord` and raises `sweepDone` on the same edge. The output then holds there.
- R5: With `noDwell` = 1, the step that meets or passes `endWord` sets the output back to `startWord` and raises `sweepDone`. The output stays at `startWord` while `profSel` stays high. Only a low-then-high on `profSel` starts a new sweep.
- R6: With `autoClr` = 1 and sweeping enabled, an `updStrobe` cycle makes the output 0 after the next edge. One edge later the output is `startWord` and a fresh sweep is under way.
- R7: While `staticClr` = 1 and sweeping is enabled, the output is 0 after each edge and never increments. After `staticClr` is released, the output stays 0 until a new sweep is launched.
- R8: A step never overshoots `endWord`, even when the 48-bit sum overflows. The final value is always `endWord` itself.
- R9: A ramp value of 0 gives one step on every clock cycle.
- R10: `profSel` passes through a two-flop synchronizer. A level first sampled high at edge k loads the start word and the countdown at edge k+2. A level held high launches only one sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startWord | input | 48 | Sweep start / single-tone tuning word |
| endWord | input | 48 | Sweep end tuning word |
| deltaWord | input | 48 | Increment per step |
| rampRate | input | 16 | Cycles between steps minus one |
| updStrobe | input | 1 | Update strobe, one cycle per event |
| sweepEn | input | 1 | 1 selects sweep mode, 0 single tone |
| noDwell | input | 1 | 1 returns to start word at sweep end |
| reloadOnUpd | input | 1 | 1 lets the strobe restart the countdown |
| autoClr | input | 1 | 1 lets the strobe clear and restart the accumulator |
| staticClr | input | 1 | 1 holds the accumulator at zero |
| profSel | input | 1 | Asynchronous sweep launch pin, rising edge |
| tuningWord | output | 48 | Tuning word to the phase accumulator |
| sweepDone | output | 1 | Sweep has reached its end |

## Verification
The assertions are checked on every cycle. They cover:
- the zero output one edge after a static or automatic clear;
- the exact end or start word on the edge where `sweepDone` rises;
- a frozen output for as long as `sweepDone` stays high.

Only the bench's scenarios can show the timing properties: the step spacing, the two-edge launch latency, the countdown restarts caused by the strobe, the restart after an automatic clear, and the single launch per `profSel` level. For these, a behavioural model is compared with the outputs every cycle across fixed scenarios.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef struct packed {
    logic clear;
    logic loadStart;
    logic step;
  } accCmd_t;
endpackage

// File: rtl/sweep_sync.sv
module sweep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], din};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int RAMP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sweepEn,
  input  logic              staticClr,
  input  logic              autoClr,
  input  logic              reloadOnUpd,
  input  logic              updStrobe,
  input  logic              startPulse,
  input  logic [RAMP_W-1:0] rampRate,
  input  logic              reachEnd,
  output accCmd_t           cmd,
  output logic              sweepDone
);
  logic              running, runningNext;
  logic              pending, pendingNext;
  logic              doneNext;
  logic [RAMP_W-1:0] cnt, cntNext;

  always_comb begin
    cmd         = '0;
    runningNext = running;
    pendingNext = pending;
    doneNext    = sweepDone;
    cntNext     = cnt;
    if (!sweepEn) begin
      cmd.loadStart = 1'b1;
      runningNext   = 1'b0;
      pendingNext   = 1'b0;
      doneNext      = 1'b0;
    end else if (staticClr) begin
      cmd.clear   = 1'b1;
      runningNext = 1'b0;
      pendingNext = 1'b0;
      doneNext    = 1'b0;
      cntNext     = '0;
    end else if (updStrobe && autoClr) begin
      cmd.clear   = 1'b1;
      runningNext = 1'b0;
      pendingNext = 1'b1;
      doneNext    = 1'b0;
    end else if (pending || startPulse) begin
      cmd.loadStart = 1'b1;
      runningNext   = 1'b1;
      pendingNext   = 1'b0;
      doneNext      = 1'b0;
      cntNext       = rampRate;
    end else if (running) begin
      if (updStrobe && reloadOnUpd) begin
        cntNext = rampRate;
      end else if (cnt == '0) begin
        cmd.step = 1'b1;
        if (reachEnd) begin
          runningNext = 1'b0;
          doneNext    = 1'b1;
        end else begin
          cntNext = rampRate;
        end
      end else begin
        cntNext = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      pending   <= 1'b0;
      sweepDone <= 1'b0;
      cnt       <= '0;
    end else begin
      running   <= runningNext;
      pending   <= pendingNext;
      sweepDone <= doneNext;
      cnt       <= cntNext;
    end
  end
endmodule

// File: rtl/sweep_datapath.sv
module sweep_datapath
  import sweep_pkg::*;
#(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rstN,
  input  accCmd_t      cmd,
  input  logic [W-1:0] startWord,
  input  logic [W-1:0] endWord,
  input  logic [W-1:0] deltaWord,
  input  logic         noDwell,
  output logic [W-1:0] acc,
  output logic         reachEnd
);
  logic [W:0] sum;

  assign sum      = {1'b0, acc} + {1'b0, deltaWord};
  assign reachEnd = (sum >= {1'b0, endWord});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              acc <= '0;
    else if (cmd.clear)     acc <= '0;
    else if (cmd.loadStart) acc <= startWord;
    else if (cmd.step)      acc <= reachEnd ? (noDwell ? startWord : endWord) : sum[W-1:0];
  end
endmodule

// File: rtl/lin_sweep.sv
module lin_sweep
  import sweep_pkg::*;
#(
  parameter int W           = 48,
  parameter int RAMP_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [W-1:0]      startWord,
  input  logic [W-1:0]      endWord,
  input  logic [W-1:0]      deltaWord,
  input  logic [RAMP_W-1:0] rampRate,
  input  logic              updStrobe,
  input  logic              sweepEn,
  input  logic              noDwell,
  input  logic              reloadOnUpd,
  input  logic              autoClr,
  input  logic              staticClr,
  input  logic              profSel,
  output logic [W-1:0]      tuningWord,
  output logic              sweepDone
);
  accCmd_t      cmd;
  logic         startPulse;
  logic         reachEnd;
  logic [W-1:0] acc;

  sweep_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din(profSel), .rise(startPulse)
  );

  sweep_ctrl #(.RAMP_W(RAMP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sweepEn(sweepEn), .staticClr(staticClr),
    .autoClr(autoClr), .reloadOnUpd(reloadOnUpd), .updStrobe(updStrobe),
    .startPulse(startPulse), .rampRate(rampRate), .reachEnd(reachEnd),
    .cmd(cmd), .sweepDone(sweepDone)
  );

  sweep_datapath #(.W(W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .startWord(startWord),
    .endWord(endWord), .deltaWord(deltaWord), .noDwell(noDwell),
    .acc(acc), .reachEnd(reachEnd)
  );

  assign tuningWord = sweepEn ? acc : startWord;
endmodule

// File: rtl/sweep_chk.sv
module sweep_chk #(
  parameter int W = 48
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] startWord,
  input logic [W-1:0] endWord,
  input logic         updStrobe,
  input logic         sweepEn,
  input logic         noDwell,
  input logic         autoClr,
  input logic         staticClr,
  input logic [W-1:0] tuningWord,
  input logic         sweepDone
);
  AST_STATIC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (sweepEn && staticClr) |=> (!sweepEn || tuningWord == '0)); // R7

  AST_AUTO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (sweepEn && !staticClr && autoClr && updStrobe) |=> (!sweepEn || tuningWord == '0)); // R6

  AST_END_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sweepDone) && sweepEn && !noDwell && $stable(endWord) && $stable(noDwell))
      |-> (tuningWord == endWord)); // R8

  AST_RETURN_START: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sweepDone) && sweepEn && noDwell && $stable(startWord) && $stable(noDwell))
      |-> (tuningWord == startWord)); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (sweepDone && $past(sweepDone) && sweepEn && $past(sweepEn))
      |-> $stable(tuningWord)); // R4
endmodule

bind lin_sweep sweep_chk #(.W(W)) uChk (
  .clk(clk), .rstN(rstN), .startWord(startWord), .endWord(endWord),
  .updStrobe(updStrobe), .sweepEn(sweepEn), .noDwell(noDwell),
  .autoClr(autoClr), .staticClr(staticClr), .tuningWord(tuningWord),
  .sweepDone(sweepDone)
);

// File: tb/tb_lin_sweep.sv
module tb_lin_sweep;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [47:0] startWord = '0, endWord = '0, deltaWord = '0;
  logic [15:0] rampRate = '0;
  logic updStrobe = 0, sweepEn = 0, noDwell = 0, reloadOnUpd = 0;
  logic autoClr = 0, staticClr = 0, profSel = 0;
  logic [47:0] tuningWord;
  logic        sweepDone;

  int checks = 0, failures = 0;
  string curReq = "R1";
  bit finished = 0;

  always #2.5 clk = ~clk;

  lin_sweep dut (
    .clk(clk), .rstN(rstN), .startWord(startWord), .endWord(endWord),
    .deltaWord(deltaWord), .rampRate(rampRate), .updStrobe(updStrobe),
    .sweepEn(sweepEn), .noDwell(noDwell), .reloadOnUpd(reloadOnUpd),
    .autoClr(autoClr), .staticClr(staticClr), .profSel(profSel),
    .tuningWord(tuningWord), .sweepDone(sweepDone)
  );

  // behavioural reference model
  logic [47:0] mFreq = '0;
  int  mWait = 0;
  bit  mRun = 0, mDone = 0, mPend = 0;
  bit  pinHist[$] = '{0, 0, 0};

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFreq = '0; mWait = 0; mRun = 0; mDone = 0; mPend = 0;
      pinHist = '{0, 0, 0};
    end else begin
      bit launch;
      logic [48:0] nxt;
      launch = pinHist[1] && !pinHist[2];
      nxt = {1'b0, mFreq} + {1'b0, deltaWord};
      if (!sweepEn) begin
        mFreq = startWord; mRun = 0; mDone = 0; mPend = 0;
      end else if (staticClr) begin
        mFreq = '0; mRun = 0; mDone = 0; mPend = 0; mWait = 0;
      end else if (updStrobe && autoClr) begin
        mFreq = '0; mRun = 0; mDone = 0; mPend = 1;
      end else if (mPend || launch) begin
        mFreq = startWord; mRun = 1; mDone = 0; mPend = 0; mWait = int'(rampRate);
      end else if (mRun) begin
        if (updStrobe && reloadOnUpd) mWait = int'(rampRate);
        else if (mWait == 0) begin
          if (nxt >= {1'b0, endWord}) begin
            mFreq = noDwell ? startWord : endWord;
            mRun = 0; mDone = 1;
          end else begin
            mFreq = nxt[47:0];
            mWait = int'(rampRate);
          end
        end else mWait = mWait - 1;
      end
      pinHist.push_front(profSel);
      void'(pinHist.pop_back());
    end
  end

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #2;
    if (!finished) begin
      check(curReq, tuningWord, sweepEn ? mFreq : startWord);
      check(curReq, {47'b0, sweepDone}, {47'b0, mDone});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic launchSweep();
    profSel = 0; cyc(4);
    profSel = 1;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    startWord = 48'h1234;
    cyc(3);
    check("R1 reset", tuningWord, 48'h1234);
    check("R1 reset done", {47'b0, sweepDone}, 48'h0);
    rstN = 1; cyc(2);
    startWord = 48'hABCDE; cyc(1);
    check("R1 single tone", tuningWord, 48'hABCDE);

    // R2/R10/R8/R4: start 100, end 200, delta 30, ramp 2
    curReq = "R2";
    startWord = 100; endWord = 200; deltaWord = 30; rampRate = 2;
    sweepEn = 1; cyc(2);
    launchSweep();
    cyc(5); check("R10 launch latency", tuningWord, 100);
    cyc(1); check("R2 first step", tuningWord, 130);
    cyc(3); check("R2 second step", tuningWord, 160);
    cyc(3); check("R2 third step", tuningWord, 190);
    check("R4 not yet done", {47'b0, sweepDone}, 48'h0);
    cyc(3); check("R8 saturate at end", tuningWord, 200);
    check("R4 done flag", {47'b0, sweepDone}, 48'h1);
    curReq = "R4"; cyc(8); check("R4 hold at end", tuningWord, 200);

    // R9/R5: ramp 0 with no-dwell
    curReq = "R5";
    startWord = 1000; endWord = 1040; deltaWord = 10; rampRate = 0; noDwell = 1;
    launchSweep();
    cyc(4); check("R9 step every cycle", tuningWord, 1010);
    cyc(3); check("R5 back to start", tuningWord, 1000);
    check("R5 done flag", {47'b0, sweepDone}, 48'h1);
    cyc(10); check("R10 held level no relaunch", tuningWord, 1000);
    launchSweep();
    cyc(4); check("R5 relaunch", tuningWord, 1010);
    cyc(6); noDwell = 0;

    // R3: countdown reload
    curReq = "R3";
    startWord = 0; endWord = 1000; deltaWord = 1; rampRate = 3; reloadOnUpd = 1;
    launchSweep(); cyc(3);
    for (int i = 0; i < 10; i++) begin
      updStrobe = 1; cyc(1); updStrobe = 0; cyc(1);
    end
    check("R3 reload blocks steps", tuningWord, 0);
    reloadOnUpd = 0;
    for (int i = 0; i < 10; i++) begin
      updStrobe = 1; cyc(1); updStrobe = 0; cyc(1);
    end
    checks++;
    if (tuningWord == 0) begin
      failures++;
      $display("FAIL R3 strobe without reload bit blocked steps actual=%h expected=nonzero", tuningWord);
    end

    // R6: auto clear
    curReq = "R6";
    startWord = 500; endWord = 100000; deltaWord = 7; rampRate = 1;
    launchSweep(); cyc(12);
    autoClr = 1; updStrobe = 1; cyc(1); updStrobe = 0;
    check("R6 cleared for one cycle", tuningWord, 0);
    cyc(1); check("R6 restart at start", tuningWord, 500);
    cyc(2); check("R6 sweep resumes", tuningWord, 507);
    autoClr = 0; cyc(3);

    // R7: static clear
    curReq = "R7";
    staticClr = 1; cyc(5);
    check("R7 held at zero", tuningWord, 0);
    staticClr = 0; cyc(5);
    check("R7 stays zero until launch", tuningWord, 0);

    // R8: overflow of the sum
    curReq = "R8";
    startWord = 48'hFFFF_FFFF_FF00; endWord = 48'hFFFF_FFFF_FFF0;
    deltaWord = 48'h80; rampRate = 0;
    launchSweep();
    cyc(4); check("R8 step below end", tuningWord, 48'hFFFF_FFFF_FF80);
    cyc(1); check("R8 overflow saturates", tuningWord, 48'hFFFF_FFFF_FFF0);
    check("R8 done flag", {47'b0, sweepDone}, 48'h1);

    // R1 again
    curReq = "R1";
    sweepEn = 0; cyc(1);
    check("R1 single tone after sweep", tuningWord, 48'hFFFF_FFFF_FF00);
    cyc(1); check("R1 done cleared", {47'b0, sweepDone}, 48'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule